// File: doc/BRIEF.md
# Bus Data Width Adapter

This adapter joins a wide host port to a narrow device port on a split-transaction interconnect. Requests travel from host to device: each wide request beat is cut into narrow beats. Responses travel from device to host: narrow response beats are gathered back into wide beats. Every channel uses a valid/ready handshake. Traffic is in order and comes from a single source. A transfer's length comes only from its size field, which holds log2 of the byte count.

On the request side, the adapter carries no low-address sideband. It works out which narrow lanes of the wide beat to send from the transfer address and size alone. On the response side, the merger never looks at an address. It counts narrow beats into a group and writes each beat into its own holding register. It repeats a short group across the whole wide word, so the host can read its bytes from whichever lane its own address selects. The error flag of each merged beat is the OR of the flags of the beats in its group.

With default parameters the wide side is 8 bytes and the narrow side is 2 bytes. This gives four 16-bit lanes. Lane i is data bits [16i+15:16i].

Top module: `bus_width_adapter`

## Requirements
- R1: While reset is high, and in the first cycle after it, `dev_req_valid` and `hst_rsp_valid` are 0. In that cycle `dev_rsp_ready` and `hst_req_ready` are 1, meaning no partial merge is pending.
- R2: When a request's size is at least the wide width (size >= 3), each accepted wide beat produces four narrow beats. They carry lanes 0, 1, 2, 3 in that order.
- R3: When a request's size is below the wide width, one wide beat produces max(1, bytes/2) narrow beats. The first lane is address bits [2:1], aligned down to the beat count, and the lanes then rise by one per beat.
- R4: Every narrow request beat carries the address, size and source of the wide beat it came from, unchanged.
- R5: While `dev_req_valid` is 1 and `dev_req_ready` is 0, the next cycle still has `dev_req_valid` at 1 with the same data, address, size and source.
- R6: A response of size s is merged in groups of g = min(4, max(1, 2^s/2)) narrow beats. Beat k of a group goes to lane k, and lane j of the wide beat holds beat (j mod g).
- R7: The error flag of a merged wide beat is the OR of the error flags of the beats in its group. Flags from earlier groups do not carry over.
- R8: `hst_rsp_valid` rises only in the cycle after the last narrow beat of a group is accepted. `dev_rsp_ready` is 0 while a merged beat waits to be taken.
- R9: While `hst_rsp_valid` is 1 and `hst_rsp_ready` is 0, the next cycle keeps the same valid, data, error, size and source.
- R10: A transfer larger than the wide width is handled as 2^(s-3) wide beats. On requests they are split one after another in order. On responses each group of four narrow beats yields one wide beat, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_req_valid | input | 1 | Wide request beat valid |
| hst_req_ready | output | 1 | Wide request beat accepted |
| hst_req_addr | input | ADDR_W | Transfer address |
| hst_req_size | input | SIZE_W | log2 of the transfer bytes |
| hst_req_src | input | SRC_W | Source identifier |
| hst_req_data | input | 8*WIDE_BYTES | Wide request data |
| dev_req_valid | output | 1 | Narrow request beat valid |
| dev_req_ready | input | 1 | Narrow request beat accepted |
| dev_req_addr | output | ADDR_W | Transfer address |
| dev_req_size | output | SIZE_W | log2 of the transfer bytes |
| dev_req_src | output | SRC_W | Source identifier |
| dev_req_data | output | 8*NARROW_BYTES | Narrow request data lane |
| dev_rsp_valid | input | 1 | Narrow response beat valid |
| dev_rsp_ready | output | 1 | Narrow response beat accepted |
| dev_rsp_size | input | SIZE_W | log2 of the response bytes |
| dev_rsp_src | input | SRC_W | Source identifier |
| dev_rsp_err | input | 1 | Per-beat error flag |
| dev_rsp_data | input | 8*NARROW_BYTES | Narrow response data |
| hst_rsp_valid | output | 1 | Merged wide response valid |
| hst_rsp_ready | input | 1 | Merged wide response accepted |
| hst_rsp_size | output | SIZE_W | log2 of the response bytes |
| hst_rsp_src | output | SRC_W | Source identifier |
| hst_rsp_err | output | 1 | OR of the group's error flags |
| hst_rsp_data | output | 8*WIDE_BYTES | Merged wide response data |

## Verification
The hardest state to reach from the ports is a merge group caught in the middle: some lanes are written, the error accumulator holds a flag, and a finished wide beat may still be waiting behind a stalled host. To get there, the bench holds the host response ready low for a whole group. It checks that nothing appears before the last narrow beat and that input ready drops right after it. It then sends groups whose error flag sits on a middle beat, followed by clean groups, under random backpressure. On the request side, sub-wide transfers at every lane offset are sent while the device ready toggles randomly, so the stall path is hit partway through a split.

// File: rtl/bwa_pkg.sv
`timescale 1ns/1ps
package bwa_pkg;
  // log2 of the number of narrow beats that form one wide beat (or one group)
  function automatic int unsigned grp_log(input int unsigned sz,
                                          input int unsigned lw,
                                          input int unsigned ln);
    if (sz >= lw)      return lw - ln;
    else if (sz <= ln) return 0;
    else               return sz - ln;
  endfunction
endpackage

// File: rtl/bwa_split.sv
`timescale 1ns/1ps
module bwa_split #(
  parameter int ADDR_W       = 12,
  parameter int SIZE_W       = 3,
  parameter int SRC_W        = 4,
  parameter int WIDE_BYTES   = 8,
  parameter int NARROW_BYTES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [ADDR_W-1:0]       in_addr,
  input  logic [SIZE_W-1:0]       in_size,
  input  logic [SRC_W-1:0]        in_src,
  input  logic [WIDE_BYTES*8-1:0] in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [ADDR_W-1:0]       out_addr,
  output logic [SIZE_W-1:0]       out_size,
  output logic [SRC_W-1:0]        out_src,
  output logic [NARROW_BYTES*8-1:0] out_data
);
  import bwa_pkg::*;
  localparam int LW    = $clog2(WIDE_BYTES);
  localparam int LN    = $clog2(NARROW_BYTES);
  localparam int LR    = LW - LN;
  localparam int RATIO = WIDE_BYTES / NARROW_BYTES;
  localparam int NW    = NARROW_BYTES * 8;

  logic                    busy;
  logic [LR-1:0]           lane, left;
  logic [WIDE_BYTES*8-1:0] wide_q;
  logic [ADDR_W-1:0]       addr_q;
  logic [SIZE_W-1:0]       size_q;
  logic [SRC_W-1:0]        src_q;

  logic [LR-1:0] span, base;
  logic          in_fire, out_fire;

  always_comb begin
    int unsigned g;
    g    = grp_log(int'(in_size), LW, LN);
    span = LR'((1 << g) - 1);
    if (g == LR) base = '0;
    else         base = in_addr[LW-1:LN] & ~span;
  end

  assign out_fire = busy && out_ready;
  assign in_ready = !busy || (out_ready && left == '0);
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      lane <= '0;
      left <= '0;
    end else begin
      if (out_fire) begin
        if (left == '0) begin
          busy <= 1'b0;
        end else begin
          lane <= lane + 1'b1;
          left <= left - 1'b1;
        end
      end
      if (in_fire) begin
        busy <= 1'b1;
        lane <= base;
        left <= span;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire) begin
      wide_q <= in_data;
      addr_q <= in_addr;
      size_q <= in_size;
      src_q  <= in_src;
    end
  end

  logic [NW-1:0] lane_v [RATIO];
  for (genvar i = 0; i < RATIO; i++) begin : g_lane
    assign lane_v[i] = wide_q[i*NW +: NW];
  end

  assign out_valid = busy;
  assign out_data  = lane_v[lane];
  assign out_addr  = addr_q;
  assign out_size  = size_q;
  assign out_src   = src_q;
endmodule

// File: rtl/bwa_merge.sv
`timescale 1ns/1ps
module bwa_merge #(
  parameter int SIZE_W       = 3,
  parameter int SRC_W        = 4,
  parameter int WIDE_BYTES   = 8,
  parameter int NARROW_BYTES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [SIZE_W-1:0]         in_size,
  input  logic [SRC_W-1:0]          in_src,
  input  logic                      in_err,
  input  logic [NARROW_BYTES*8-1:0] in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [SIZE_W-1:0]         out_size,
  output logic [SRC_W-1:0]          out_src,
  output logic                      out_err,
  output logic [WIDE_BYTES*8-1:0]   out_data
);
  import bwa_pkg::*;
  localparam int LW    = $clog2(WIDE_BYTES);
  localparam int LN    = $clog2(NARROW_BYTES);
  localparam int LR    = LW - LN;
  localparam int RATIO = WIDE_BYTES / NARROW_BYTES;
  localparam int NW    = NARROW_BYTES * 8;

  logic [LR-1:0]   cnt, mask, omask;
  logic            acc, ov;
  logic [NW-1:0]   hold [RATIO];
  logic            in_fire, last;

  always_comb begin
    int unsigned g;
    g    = grp_log(int'(in_size), LW, LN);
    mask = LR'((1 << g) - 1);
  end

  assign in_ready = !ov;
  assign in_fire  = in_valid && !ov;
  assign last     = (cnt == mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      acc     <= 1'b0;
      ov      <= 1'b0;
      out_err <= 1'b0;
      omask   <= '0;
    end else begin
      if (ov && out_ready) ov <= 1'b0;
      if (in_fire) begin
        if (last) begin
          cnt     <= '0;
          acc     <= 1'b0;
          ov      <= 1'b1;
          out_err <= acc | in_err;
          omask   <= mask;
        end else begin
          cnt <= cnt + 1'b1;
          acc <= acc | in_err;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire && last) begin
      out_size <= in_size;
      out_src  <= in_src;
    end
  end

  for (genvar i = 0; i < RATIO; i++) begin : g_hold
    always_ff @(posedge clk) begin
      if (in_fire && cnt == LR'(i)) hold[i] <= in_data;
    end
    assign out_data[i*NW +: NW] = hold[LR'(i) & omask];
  end

  assign out_valid = ov;
endmodule

// File: rtl/bus_width_adapter.sv
`timescale 1ns/1ps
module bus_width_adapter #(
  parameter int ADDR_W       = 12,
  parameter int SIZE_W       = 3,
  parameter int SRC_W        = 4,
  parameter int WIDE_BYTES   = 8,
  parameter int NARROW_BYTES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      hst_req_valid,
  output logic                      hst_req_ready,
  input  logic [ADDR_W-1:0]         hst_req_addr,
  input  logic [SIZE_W-1:0]         hst_req_size,
  input  logic [SRC_W-1:0]          hst_req_src,
  input  logic [WIDE_BYTES*8-1:0]   hst_req_data,
  output logic                      dev_req_valid,
  input  logic                      dev_req_ready,
  output logic [ADDR_W-1:0]         dev_req_addr,
  output logic [SIZE_W-1:0]         dev_req_size,
  output logic [SRC_W-1:0]          dev_req_src,
  output logic [NARROW_BYTES*8-1:0] dev_req_data,
  input  logic                      dev_rsp_valid,
  output logic                      dev_rsp_ready,
  input  logic [SIZE_W-1:0]         dev_rsp_size,
  input  logic [SRC_W-1:0]          dev_rsp_src,
  input  logic                      dev_rsp_err,
  input  logic [NARROW_BYTES*8-1:0] dev_rsp_data,
  output logic                      hst_rsp_valid,
  input  logic                      hst_rsp_ready,
  output logic [SIZE_W-1:0]         hst_rsp_size,
  output logic [SRC_W-1:0]          hst_rsp_src,
  output logic                      hst_rsp_err,
  output logic [WIDE_BYTES*8-1:0]   hst_rsp_data
);
  bwa_split #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SRC_W(SRC_W),
    .WIDE_BYTES(WIDE_BYTES), .NARROW_BYTES(NARROW_BYTES)
  ) u_split (
    .clk(clk), .rst(rst),
    .in_valid(hst_req_valid), .in_ready(hst_req_ready),
    .in_addr(hst_req_addr), .in_size(hst_req_size),
    .in_src(hst_req_src), .in_data(hst_req_data),
    .out_valid(dev_req_valid), .out_ready(dev_req_ready),
    .out_addr(dev_req_addr), .out_size(dev_req_size),
    .out_src(dev_req_src), .out_data(dev_req_data)
  );

  bwa_merge #(
    .SIZE_W(SIZE_W), .SRC_W(SRC_W),
    .WIDE_BYTES(WIDE_BYTES), .NARROW_BYTES(NARROW_BYTES)
  ) u_merge (
    .clk(clk), .rst(rst),
    .in_valid(dev_rsp_valid), .in_ready(dev_rsp_ready),
    .in_size(dev_rsp_size), .in_src(dev_rsp_src),
    .in_err(dev_rsp_err), .in_data(dev_rsp_data),
    .out_valid(hst_rsp_valid), .out_ready(hst_rsp_ready),
    .out_size(hst_rsp_size), .out_src(hst_rsp_src),
    .out_err(hst_rsp_err), .out_data(hst_rsp_data)
  );
endmodule

// File: rtl/bwa_check.sv
`timescale 1ns/1ps
module bwa_check #(
  parameter int ADDR_W       = 12,
  parameter int SIZE_W       = 3,
  parameter int SRC_W        = 4,
  parameter int WIDE_BYTES   = 8,
  parameter int NARROW_BYTES = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      hst_req_ready,
  input logic                      dev_req_valid,
  input logic                      dev_req_ready,
  input logic [ADDR_W-1:0]         dev_req_addr,
  input logic [SIZE_W-1:0]         dev_req_size,
  input logic [SRC_W-1:0]          dev_req_src,
  input logic [NARROW_BYTES*8-1:0] dev_req_data,
  input logic                      dev_rsp_valid,
  input logic                      dev_rsp_ready,
  input logic                      hst_rsp_valid,
  input logic                      hst_rsp_ready,
  input logic                      hst_rsp_err,
  input logic [WIDE_BYTES*8-1:0]   hst_rsp_data
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!dev_req_valid && !hst_rsp_valid && dev_rsp_ready));

  // R4
  split_fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_req_valid && !hst_req_ready) |=>
      ($stable(dev_req_addr) && $stable(dev_req_size) && $stable(dev_req_src)));

  // R5
  req_stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_req_valid && !dev_req_ready) |=>
      (dev_req_valid && $stable(dev_req_data) && $stable(dev_req_addr)));

  // R8
  rsp_rise_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hst_rsp_valid) |-> $past(dev_rsp_valid && dev_rsp_ready));

  // R8
  rsp_pending_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    hst_rsp_valid |-> !dev_rsp_ready);

  // R9
  rsp_stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hst_rsp_valid && !hst_rsp_ready) |=>
      (hst_rsp_valid && $stable(hst_rsp_data) && $stable(hst_rsp_err)));
endmodule

bind bus_width_adapter bwa_check #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SRC_W(SRC_W),
  .WIDE_BYTES(WIDE_BYTES), .NARROW_BYTES(NARROW_BYTES)
) u_chk (
  .clk(clk), .rst(rst),
  .hst_req_ready(hst_req_ready),
  .dev_req_valid(dev_req_valid), .dev_req_ready(dev_req_ready),
  .dev_req_addr(dev_req_addr), .dev_req_size(dev_req_size),
  .dev_req_src(dev_req_src), .dev_req_data(dev_req_data),
  .dev_rsp_valid(dev_rsp_valid), .dev_rsp_ready(dev_rsp_ready),
  .hst_rsp_valid(hst_rsp_valid), .hst_rsp_ready(hst_rsp_ready),
  .hst_rsp_err(hst_rsp_err), .hst_rsp_data(hst_rsp_data)
);

// File: tb/sim_bus_width_adapter.sv
`timescale 1ns/1ps
module sim_bus_width_adapter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_req_valid = 1'b0;
  logic        hst_req_ready;
  logic [11:0] hst_req_addr = '0;
  logic [2:0]  hst_req_size = '0;
  logic [3:0]  hst_req_src = '0;
  logic [63:0] hst_req_data = '0;
  logic        dev_req_valid;
  logic        dev_req_ready = 1'b0;
  logic [11:0] dev_req_addr;
  logic [2:0]  dev_req_size;
  logic [3:0]  dev_req_src;
  logic [15:0] dev_req_data;
  logic        dev_rsp_valid = 1'b0;
  logic        dev_rsp_ready;
  logic [2:0]  dev_rsp_size = '0;
  logic [3:0]  dev_rsp_src = '0;
  logic        dev_rsp_err = 1'b0;
  logic [15:0] dev_rsp_data = '0;
  logic        hst_rsp_valid;
  logic        hst_rsp_ready = 1'b0;
  logic [2:0]  hst_rsp_size;
  logic [3:0]  hst_rsp_src;
  logic        hst_rsp_err;
  logic [63:0] hst_rsp_data;

  always #5 clk = ~clk;

  bus_width_adapter u0 (.*);

  int nchk = 0;
  int nerr = 0;
  int req_mode = 0;  // 0 ready, 1 random, 2 held low
  int rsp_mode = 0;

  logic [18:0] qa_meta [$];
  logic [15:0] qa_data [$];
  string       qa_tag  [$];
  logic [7:0]  qd_meta [$];
  logic [63:0] qd_data [$];
  string       qd_tag  [$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // sinks
  initial forever begin
    @(negedge clk);
    dev_req_ready = (req_mode == 0) ? 1'b1 : (req_mode == 1) ? ($urandom % 3 != 0) : 1'b0;
    hst_rsp_ready = (rsp_mode == 0) ? 1'b1 : (rsp_mode == 1) ? ($urandom % 3 != 0) : 1'b0;
  end

  // monitors
  initial forever begin
    @(negedge clk); #1;
    if (!rst && dev_req_valid && dev_req_ready) begin
      if (qa_data.size() == 0) chk("R2 unexpected request beat", 64'(dev_req_data), 64'hx);
      else begin
        logic [18:0] m; logic [15:0] d; string t;
        m = qa_meta.pop_front(); d = qa_data.pop_front(); t = qa_tag.pop_front();
        chk(t, 64'(dev_req_data), 64'(d));
        chk("R4 addr/size/src", 64'({dev_req_addr, dev_req_size, dev_req_src}), 64'(m));
      end
    end
  end

  initial forever begin
    @(negedge clk); #1;
    if (!rst && hst_rsp_valid && hst_rsp_ready) begin
      if (qd_data.size() == 0) chk("R6 unexpected response beat", hst_rsp_data, 64'hx);
      else begin
        logic [7:0] m; logic [63:0] d; string t;
        m = qd_meta.pop_front(); d = qd_data.pop_front(); t = qd_tag.pop_front();
        chk(t, hst_rsp_data, d);
        chk("R7 merged error", 64'(hst_rsp_err), 64'(m[7]));
        chk("R6 size/src", 64'({hst_rsp_size, hst_rsp_src}), 64'(m[6:0]));
      end
    end
  end

  task automatic send_req(input logic [11:0] addr, input logic [2:0] size,
                          input logic [3:0] src, input logic [63:0] seed, input string tag);
    int nb, g, cnt;
    logic [1:0] base;
    nb   = (size >= 3) ? (1 << (int'(size) - 3)) : 1;
    g    = (size >= 3) ? 2 : (size <= 1) ? 0 : int'(size) - 1;
    cnt  = 1 << g;
    base = (size >= 3) ? 2'd0 : (addr[2:1] & ~2'(cnt - 1));
    for (int b = 0; b < nb; b++) begin
      logic [63:0] d;
      d = seed + 64'(b) * 64'h0011_0022_0033_0044;
      for (int k = 0; k < cnt; k++) begin
        logic [1:0] ln;
        ln = base + 2'(k);
        qa_meta.push_back({addr, size, src});
        qa_data.push_back(d[ln*16 +: 16]);
        qa_tag.push_back(tag);
      end
      @(negedge clk);
      hst_req_valid = 1'b1; hst_req_addr = addr; hst_req_size = size;
      hst_req_src = src; hst_req_data = d;
      #1;
      while (!hst_req_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    hst_req_valid = 1'b0;
  endtask

  task automatic send_rsp(input logic [2:0] size, input logic [3:0] src,
                          input logic [15:0] seed, input int errs,
                          input bit peek, input string tag);
    int nb, g;
    logic [15:0] nd [64];
    nb = (size <= 1) ? 1 : (1 << (int'(size) - 1));
    g  = (nb < 4) ? nb : 4;
    for (int k = 0; k < nb; k++) nd[k] = seed + 16'(k * 16'h0101);
    for (int grp = 0; grp < nb / g; grp++) begin
      logic [63:0] w; logic e;
      e = 1'b0;
      for (int j = 0; j < 4; j++) w[j*16 +: 16] = nd[grp*g + (j % g)];
      for (int k = 0; k < g; k++) e = e | errs[grp*g + k];
      qd_meta.push_back({e, size, src});
      qd_data.push_back(w);
      qd_tag.push_back(tag);
    end
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      dev_rsp_valid = 1'b1; dev_rsp_size = size; dev_rsp_src = src;
      dev_rsp_err = errs[k]; dev_rsp_data = nd[k];
      #1;
      if (peek && k == g - 1) chk("R8 no output before last beat", 64'(hst_rsp_valid), 64'd0);
      while (!dev_rsp_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    dev_rsp_valid = 1'b0;
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 during reset
    chk("R1 dev_req_valid in reset", 64'(dev_req_valid), 64'd0);
    chk("R1 hst_rsp_valid in reset", 64'(hst_rsp_valid), 64'd0);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 dev_rsp_ready after reset", 64'(dev_rsp_ready), 64'd1);
    chk("R1 hst_req_ready after reset", 64'(hst_req_ready), 64'd1);

    // R2 full wide beat, R3 sub-wide lane choice
    send_req(12'h100, 3'd3, 4'h1, 64'h4444_3333_2222_1111, "R2 wide lanes");
    send_req(12'h006, 3'd1, 4'h2, 64'hDDDD_CCCC_BBBB_AAAA, "R3 two-byte lane 3");
    send_req(12'h004, 3'd2, 4'h3, 64'h8888_7777_6666_5555, "R3 four-byte lanes 2,3");
    send_req(12'h00A, 3'd0, 4'h4, 64'h0F0E_0D0C_0B0A_0908, "R3 one-byte lane 1");
    send_req(12'h002, 3'd0, 4'h5, 64'h1357_9BDF_2468_ACE0, "R3 one-byte lane 1 low");
    // R10 multi-beat burst
    send_req(12'h040, 3'd5, 4'h6, 64'hA5A5_5A5A_C3C3_3C3C, "R10 burst split");

    // R8: group completes only at last beat; input blocked while pending
    rsp_mode = 2;
    @(negedge clk); @(negedge clk);
    send_rsp(3'd3, 4'h7, 16'h1000, 0, 1'b1, "R6 full group");
    #1;
    chk("R8 valid after last beat", 64'(hst_rsp_valid), 64'd1);
    chk("R8 input blocked while pending", 64'(dev_rsp_ready), 64'd0);
    rsp_mode = 0;
    repeat (3) @(negedge clk);

    // R6 replication of short groups
    send_rsp(3'd0, 4'h8, 16'hBEEF, 0, 1'b0, "R6 single beat replicated");
    send_rsp(3'd2, 4'h9, 16'h2200, 0, 1'b0, "R6 two-beat group replicated");
    // R7 error OR per group, no carry
    send_rsp(3'd3, 4'hA, 16'h3300, 32'b0100, 1'b0, "R7 error mid group");
    send_rsp(3'd4, 4'hB, 16'h4400, 32'b0000_0010, 1'b0, "R10 two groups");
    send_rsp(3'd2, 4'hC, 16'h5500, 32'b11, 1'b0, "R7 all errors");

    // random backpressure on both sides (R5, R9)
    req_mode = 1; rsp_mode = 1;
    for (int i = 0; i < 8; i++) begin
      send_req(12'(i * 2), 3'(i % 4), 4'(i), {$urandom, $urandom}, "R5 stalled split");
      send_rsp(3'(i % 6), 4'(i), 16'($urandom), int'($urandom % 64), 1'b0, "R9 stalled merge");
    end
    req_mode = 0; rsp_mode = 0;
    repeat (30) @(negedge clk);
    chk("R2 request queue drained", 64'(qa_data.size()), 64'd0);
    chk("R6 response queue drained", 64'(qd_data.size()), 64'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule